// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery Slicer

This block sits behind a tone discriminator that delivers one hard decision per audio sample, eight samples for each 1200-baud symbol. It keeps its own estimate of where each symbol lies in time with a small signed phase register. Each accepted sample moves that register forward by a fixed amount. When the register passes its limit, a symbol instant has come.

A tone change seen in the sample stream pulls the phase. A change that arrives in the early half of the phase window moves it forward, and one in the late half moves it back. Over time the sampling instant settles near the middle of each symbol.

At every symbol instant the three most recent decisions vote to give a line level. That level is compared with the level recovered at the previous instant. No change gives a data 1, and a change gives a data 0. The resulting data bit appears with a one-cycle strobe, ready for a downstream framer.

Internally, each accepted sample is classified by the transition it carries, using three named adjustment kinds. ADJ_NONE means the newest two decisions are equal. ADJ_ADVANCE means they differ and the phase lies below the threshold. ADJ_RETARD means they differ and the phase is at or above the threshold. The kinds are chosen with a unique case.

Top module: `bitclk_slicer`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `bit_vld` and `bit_out` are 0. The phase register, the 8-bit decision history and the previously recovered level all start at 0.
- R2: A cycle with `smp_vld` low changes neither the history nor the phase, and `bit_vld` is 0 in the following cycle.
- R3: Each accepted decision enters the history at bit 0, and the older bits move up by one place. A transition is present when history bits 0 and 1 differ after the shift, which includes the sample just accepted.
- R4: On a transition, the phase first moves by `PH_STEP` (default 4). The move is an increase if the phase is below the threshold `PH_MAX/2`, and a decrease otherwise.
- R5: After any such move, every accepted sample adds `PH_INC` (default 8). When the sum reaches `PH_MAX = 8*PH_INC` or more, `PH_MAX` is subtracted and one bit is emitted. With no transitions, a bit is emitted exactly every 8 accepted samples, and two emitted bits never fall in adjacent cycles.
- R6: The recovered level at a bit instant is 1 when at least two of history bits 2, 1 and 0 are 1 (patterns 111, 110, 101, 011), counted after the current sample has been shifted in.
- R7: `bit_out` is 1 when the recovered level equals the level recovered at the previous bit instant, and 0 when the two differ. The previous level after reset is 0.
- R8: `bit_vld` is high for exactly the one cycle after the clock edge that accepted the sample which triggered the bit. `bit_out` changes only in that same cycle and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Decision strobe, one accepted sample per high cycle |
| smp_bit | input | 1 | Tone decision for this sample |
| bit_vld | output | 1 | One-cycle strobe for a decoded data bit |
| bit_out | output | 1 | Decoded data bit after NRZI decoding |

## Verification
The bench builds the block with its default values: an increment of 8, a nudge of 4, a phase limit of 64 and a threshold of 32. With these values a single transition shifts the next bit instant by half a sample, so two early nudges move a tick by a whole sample. This makes the advance and retard paths visible at the output strobe timing. Streams that start off-centre, that carry noise flips, and that pause between strobes drive the phase through both halves of the window. They also present every vote pattern at bit instants.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int SMP_PER_BIT = 8;
    localparam int HIST_W      = 8;

    typedef enum logic [1:0] {
        ADJ_NONE    = 2'd0,
        ADJ_ADVANCE = 2'd1,
        ADJ_RETARD  = 2'd2
    } adj_e;
endpackage

// File: rtl/bcs_history.sv
module bcs_history
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              smp_bit,
    output logic [HIST_W-1:0] hist_q,
    output logic              edge_seen,
    output logic [2:0]        trio
);
    logic [HIST_W-1:0] hist_nx;

    always_comb begin
        hist_nx   = {hist_q[HIST_W-2:0], smp_bit};
        edge_seen = hist_nx[1] ^ hist_nx[0];
        trio      = hist_nx[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else if (smp_vld)
            hist_q <= hist_nx;
    end
endmodule

// File: rtl/bcs_phase.sv
module bcs_phase
    import bcs_pkg::*;
#(
    parameter int PH_W    = 8,
    parameter int PH_INC  = 8,
    parameter int PH_STEP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic                   edge_seen,
    output logic signed [PH_W-1:0] phase_q,
    output logic                   tick
);
    localparam int PH_MAX = SMP_PER_BIT * PH_INC;
    localparam int PH_THR = PH_MAX / 2;
    localparam logic signed [PH_W:0] C_INC  = (PH_W+1)'(PH_INC);
    localparam logic signed [PH_W:0] C_STEP = (PH_W+1)'(PH_STEP);
    localparam logic signed [PH_W:0] C_MAX  = (PH_W+1)'(PH_MAX);
    localparam logic signed [PH_W:0] C_THR  = (PH_W+1)'(PH_THR);

    adj_e                   adj;
    logic signed [PH_W:0]   cur;
    logic signed [PH_W:0]   nudged;
    logic signed [PH_W:0]   adv;
    logic signed [PH_W:0]   wrapped;
    logic signed [PH_W-1:0] phase_d;

    always_comb begin
        cur = {phase_q[PH_W-1], phase_q};
        if (!edge_seen)
            adj = ADJ_NONE;
        else if (cur < C_THR)
            adj = ADJ_ADVANCE;
        else
            adj = ADJ_RETARD;

        unique case (adj)
            ADJ_ADVANCE: nudged = cur + C_STEP;
            ADJ_RETARD:  nudged = cur - C_STEP;
            default:     nudged = cur;
        endcase

        adv     = nudged + C_INC;
        tick    = smp_vld && (adv >= C_MAX);
        wrapped = (adv >= C_MAX) ? (adv - C_MAX) : adv;
        phase_d = wrapped[PH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (smp_vld)
            phase_q <= phase_d;
    end
endmodule

// File: rtl/bcs_decide.sv
module bcs_decide (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] trio,
    output logic       bit_vld,
    output logic       bit_out
);
    logic level;
    logic prev_q;

    always_comb level = (trio[0] & trio[1]) | (trio[0] & trio[2]) | (trio[1] & trio[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            bit_vld <= 1'b0;
            bit_out <= 1'b0;
        end else begin
            bit_vld <= tick;
            if (tick) begin
                prev_q  <= level;
                bit_out <= (level == prev_q);
            end
        end
    end
endmodule

// File: rtl/bitclk_slicer.sv
module bitclk_slicer
    import bcs_pkg::*;
#(
    parameter int PH_W    = 8,
    parameter int PH_INC  = 8,
    parameter int PH_STEP = PH_INC / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic smp_bit,
    output logic bit_vld,
    output logic bit_out
);
    logic [HIST_W-1:0]      hist_q;
    logic                   edge_seen;
    logic [2:0]             trio;
    logic signed [PH_W-1:0] phase_q;
    logic                   tick;

    bcs_history u_hist (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .hist_q(hist_q), .edge_seen(edge_seen), .trio(trio)
    );

    bcs_phase #(.PH_W(PH_W), .PH_INC(PH_INC), .PH_STEP(PH_STEP)) u_phase (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .edge_seen(edge_seen),
        .phase_q(phase_q), .tick(tick)
    );

    bcs_decide u_dec (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trio(trio),
        .bit_vld(bit_vld), .bit_out(bit_out)
    );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int PH_W   = 8,
    parameter int PH_INC = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   smp_vld,
    input logic                   smp_bit,
    input logic                   bit_vld,
    input logic                   bit_out,
    input logic [HIST_W-1:0]      hist_q,
    input logic signed [PH_W-1:0] phase_q
);
    localparam int PH_MAX = SMP_PER_BIT * PH_INC;

    AST_IDLE_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !bit_vld); // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(hist_q) && $stable(phase_q))); // R2
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (hist_q[0] == $past(smp_bit)) && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R3
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q >= 0) && (int'(phase_q) < PH_MAX)); // R5
    AST_NO_ADJ_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> $stable(bit_out)); // R8
endmodule

bind bitclk_slicer bcs_checker #(.PH_W(PH_W), .PH_INC(PH_INC)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .bit_vld(bit_vld), .bit_out(bit_out), .hist_q(hist_q), .phase_q(phase_q)
);

// File: tb/bitclk_slicer_tb_top.sv
module bitclk_slicer_tb_top;
    localparam int INC  = 8;
    localparam int STEP = 4;
    localparam int MAXP = 8 * INC;
    localparam int THR  = MAXP / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic smp_bit = 1'b0;
    logic bit_vld;
    logic bit_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit smp_q[$];
    int m_phase = 0;
    int m_prev = 0;
    int m_out = 0;
    int m_vld = 0;
    int ticks = 0;
    int tick_at = 0;
    int nrz = 0;

    always #10 clk = ~clk;

    bitclk_slicer #(.PH_W(8), .PH_INC(INC), .PH_STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .bit_vld(bit_vld), .bit_out(bit_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        smp_q.delete();
        for (int i = 0; i < 8; i++) smp_q.push_back(1'b0);
        m_phase = 0; m_prev = 0; m_out = 0; m_vld = 0;
    endtask

    task automatic step(input bit v, input bit b, input string tag);
        int ones;
        smp_vld = v;
        smp_bit = b;
        m_vld = 0;
        if (v) begin
            smp_q.push_back(b);
            void'(smp_q.pop_front());
            if (smp_q[7] != smp_q[6])
                m_phase = (m_phase < THR) ? m_phase + STEP : m_phase - STEP;
            m_phase += INC;
            if (m_phase >= MAXP) begin
                m_phase -= MAXP;
                ones = int'(smp_q[7]) + int'(smp_q[6]) + int'(smp_q[5]);
                m_out = ((ones >= 2 ? 1 : 0) == m_prev) ? 1 : 0;
                m_prev = (ones >= 2) ? 1 : 0;
                m_vld = 1;
                ticks++;
            end
        end
        @(negedge clk);
        chk(bit_vld == 1'(m_vld), {tag, " strobe"}, int'(bit_vld), m_vld);
        chk(bit_out == 1'(m_out), {tag, " data"}, int'(bit_out), m_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk(bit_vld == 1'b0, "R1 reset strobe", int'(bit_vld), 0);
        chk(bit_out == 1'b0, "R1 reset data", int'(bit_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bit_vld == 1'b0, "R1 after release", int'(bit_vld), 0);

        // R5: steady zeros, one bit per 8 samples; R7 first bit equals reset level -> 1
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, "R5");
            if (i == 7) begin
                chk(bit_vld == 1'b1, "R5 eighth sample ticks", int'(bit_vld), 1);
                chk(bit_out == 1'b1, "R7 same level gives 1", int'(bit_out), 1);
            end
        end
        chk(ticks == 5, "R5 tick count", ticks, 5);

        // R2: idle cycles between strobes
        for (int i = 0; i < 20; i++) step(1'(i % 3 == 0), 1'b0, "R2");

        // R4: from reset, two early transitions make the tick land on sample 7
        rst_n = 1'b0; model_reset(); @(negedge clk); rst_n = 1'b1; @(negedge clk);
        tick_at = 0;
        for (int i = 0; i < 8; i++) begin
            step(1'b1, (i == 0) ? 1'b1 : 1'b0, "R4");
            if (bit_vld && tick_at == 0) tick_at = i + 1;
        end
        chk(tick_at == 7, "R4 advanced tick sample", tick_at, 7);

        // R3 R6 R7: NRZI data stream with an off-centre start
        for (int i = 0; i < 3; i++) step(1'b1, 1'(nrz), "R3");
        for (int k = 0; k < 120; k++) begin
            bit d = 1'($urandom_range(0, 1));
            if (!d) nrz ^= 1;
            for (int s = 0; s < 8; s++) step(1'b1, 1'(nrz), "R7");
        end

        // R6 R8: noisy samples, random gaps
        for (int k = 0; k < 2000; k++) begin
            bit v = ($urandom_range(0, 9) != 0);
            bit b = 1'(nrz);
            if (k % 8 == 0 && $urandom_range(0, 2) == 0) nrz ^= 1;
            if ($urandom_range(0, 5) == 0) b = ~b;
            step(v, b, "R6");
        end

        // R4: fully random decisions exercise retard path as well
        for (int k = 0; k < 1500; k++) step(1'b1, 1'($urandom_range(0, 1)), "R4");
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, "R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule